// File: doc/BRIEF.md
# Serial line break detector

This block watches the receive line of an asynchronous serial port. It takes one sampled line value per bit tick from the receiver's bit timing. When the line has been sampled low for a set number of consecutive bit times, it declares a break. The default number is eleven. It counts only bit ticks and takes no notice of the frame format. Eleven bit times cover a whole frame of either kind: a start bit, eight data bits and two stop-bit times, or a start bit, nine data bits and one stop bit.

A detected break sets a status flag. The flag stays set until software clears it or the block is reset. The block can also raise a one-cycle request that resets the device and enters the boot loader. It does this only when the serial port is enabled and a separate break-reset enable is set. After a break, the line must be sampled high at least once before another break can be declared.

Top module: `brk_detect`

## Requirements
- R1: On the bit tick that gives the BREAK_BITS-th consecutive low sample, `brk_flag` reads 1 from the next clock cycle.
- R2: A bit tick with `rx_bit` = 1 clears the low-run count to zero. Fewer than BREAK_BITS lows followed by a high sample never set the flag.
- R3: Cycles with `bit_tick` = 0 do not change the low-run count, whatever the value of `rx_bit`.
- R4: `brk_flag` stays at 1 until `sw_clear` = 1 is seen. It then reads 0 from the next cycle, unless R8 applies.
- R5: When `port_en` = 1 and `brk_rst_en` = 1 on the detecting tick, `brk_reset_req` is 1 for exactly one cycle. That cycle is the same one in which the flag first reads 1.
- R6: If `port_en` = 0 or `brk_rst_en` = 0 on the detecting tick, `brk_reset_req` stays 0. The flag is still set.
- R7: After a break, further low ticks neither set the flag again nor raise a request until one tick samples `rx_bit` = 1.
- R8: If `sw_clear` = 1 in the same cycle as a detecting tick, the flag is set.
- R9: After reset, `brk_flag` = 0 and `brk_reset_req` = 0. The low-run count is zero and detection is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 1 | Sampled receive line value, valid when bit_tick is 1 |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| port_en | input | 1 | Serial port enabled |
| brk_rst_en | input | 1 | Allows a break to request a reset and boot-loader entry |
| sw_clear | input | 1 | Software clear of the break flag |
| brk_flag | output | 1 | Sticky break status |
| brk_reset_req | output | 1 | One-cycle reset and boot-loader request |

## Verification
The bench builds the block with the default BREAK_BITS of 11. It therefore walks the full eleven-tick run and the near miss of ten lows followed by a high. Idle cycles with the line held low fall between ticks, so the tests show that only ticks count. The same eleven-bit run exercises both enable gates, the saturated state after a break, and a clear that lands on the detecting tick.

// File: rtl/brk_pkg.sv
package brk_pkg;
    typedef struct packed {
        logic flag;
        logic req;
    } brk_stat_t;
endpackage

// File: rtl/brk_run_counter.sv
module brk_run_counter #(
    parameter int BREAK_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic rx_bit,
    output logic hit
);
    localparam int CW = $clog2(BREAK_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(BREAK_BITS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          armed;
    } run_t;

    run_t run_d, run_q;

    always_comb begin
        run_d = run_q;
        hit   = 1'b0;
        if (bit_tick) begin
            if (rx_bit) begin
                run_d.cnt   = '0;
                run_d.armed = 1'b1;
            end else if (run_q.armed) begin
                run_d.cnt = run_q.cnt + 1'b1;
                if (run_q.cnt == LAST) begin
                    hit         = 1'b1;
                    run_d.armed = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '{cnt: '0, armed: 1'b1};
        end else begin
            run_q <= run_d;
        end
    end

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run_q.cnt <= CW'(BREAK_BITS));
    p_high_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && rx_bit) |=> (run_q.cnt == '0));
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(run_q));
endmodule

// File: rtl/brk_status.sv
module brk_status
    import brk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic port_en,
    input  logic brk_rst_en,
    input  logic sw_clear,
    output brk_stat_t stat
);
    brk_stat_t stat_d, stat_q;

    always_comb begin
        stat_d.flag = hit | (stat_q.flag & ~sw_clear);
        stat_d.req  = hit & port_en & brk_rst_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat = stat_q;

    p_fall_needs_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q.flag) |-> $past(sw_clear));
    p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q.req |=> !stat_q.req);
    p_clear_loses_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> stat_q.flag);
endmodule

// File: rtl/brk_detect.sv
module brk_detect
    import brk_pkg::*;
#(
    parameter int BREAK_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic bit_tick,
    input  logic port_en,
    input  logic brk_rst_en,
    input  logic sw_clear,
    output logic brk_flag,
    output logic brk_reset_req
);
    logic      hit;
    brk_stat_t stat;

    brk_run_counter #(.BREAK_BITS(BREAK_BITS)) i_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .rx_bit   (rx_bit),
        .hit      (hit)
    );

    brk_status i_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .port_en    (port_en),
        .brk_rst_en (brk_rst_en),
        .sw_clear   (sw_clear),
        .stat       (stat)
    );

    assign brk_flag      = stat.flag;
    assign brk_reset_req = stat.req;

    p_rise_on_low_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_flag) |-> $past(bit_tick && !rx_bit));
    p_req_with_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        brk_reset_req |-> brk_flag);
    p_req_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        brk_reset_req |-> $past(port_en && brk_rst_en));
endmodule

// File: tb/test_brk_detect.sv
`timescale 1ns/1ps
module test_brk_detect;
    localparam int N = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b1, bit_tick = 1'b0, port_en = 1'b1, brk_rst_en = 1'b1, sw_clear = 1'b0;
    logic brk_flag, brk_reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_run = 0;
    bit m_armed = 1;
    bit m_flag = 0;
    bit m_req = 0;

    always #4 clk = ~clk;

    brk_detect #(.BREAK_BITS(N)) i_brk_detect (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .bit_tick(bit_tick),
        .port_en(port_en), .brk_rst_en(brk_rst_en), .sw_clear(sw_clear),
        .brk_flag(brk_flag), .brk_reset_req(brk_reset_req)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_armed = 1; m_flag = 0; m_req = 0;
        end else begin
            bit det;
            det = bit_tick && !rx_bit && m_armed && (m_run == N - 1);
            if (bit_tick) begin
                if (rx_bit) begin
                    m_run = 0; m_armed = 1;
                end else if (m_armed) begin
                    m_run = m_run + 1;
                    if (m_run == N) m_armed = 0;
                end
            end
            m_req  = det && port_en && brk_rst_en;
            m_flag = det || (m_flag && !sw_clear);
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic t, input logic rx, input logic clr);
        bit_tick = t; rx_bit = rx; sw_clear = clr;
        @(negedge clk);
        chk("R1 flag vs model", brk_flag, m_flag);
        chk("R5 request vs model", brk_reset_req, m_req);
    endtask

    task automatic lows(input int n);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b0, 1'b0);
            if (i != n - 1) begin
                step(1'b0, 1'b0, 1'b0);
                step(1'b0, 1'b1, 1'b0);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        @(negedge clk);
        chk("R9 reset flag", brk_flag, 1'b0);
        chk("R9 reset request", brk_reset_req, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 1'b0);

        // R1 and R5: full run with both enables set; R3: idle cycles between ticks
        lows(N - 1);
        chk("R3 no flag before last tick", brk_flag, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        chk("R1 flag after eleven lows", brk_flag, 1'b1);
        chk("R5 request pulse", brk_reset_req, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        chk("R5 request one cycle only", brk_reset_req, 1'b0);

        // R7: stays saturated while the line stays low
        lows(5);
        chk("R7 no new request", brk_reset_req, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        chk("R4 clear drops flag", brk_flag, 1'b0);
        lows(N + 2);
        chk("R7 no retrigger without high", brk_flag, 1'b0);

        // R2: near misses
        step(1'b1, 1'b1, 1'b0);
        lows(N - 1);
        step(1'b1, 1'b1, 1'b0);
        lows(N - 1);
        step(1'b1, 1'b1, 1'b0);
        chk("R2 ten lows then high", brk_flag, 1'b0);

        // R6: each enable low
        port_en = 1'b0;
        lows(N);
        chk("R6 flag with port off", brk_flag, 1'b1);
        chk("R6 no request with port off", brk_reset_req, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b0);
        port_en = 1'b1; brk_rst_en = 1'b0;
        lows(N);
        chk("R6 flag with reset enable off", brk_flag, 1'b1);
        chk("R6 no request with reset enable off", brk_reset_req, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b0);
        chk("R4 flag sticky", brk_flag, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        brk_rst_en = 1'b1;

        // R8: clear on the detecting tick
        step(1'b1, 1'b1, 1'b0);
        lows(N - 1);
        step(1'b1, 1'b0, 1'b1);
        chk("R8 set wins over clear", brk_flag, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        chk("R4 clear after break", brk_flag, 1'b0);

        // R3: long low with no ticks
        step(1'b1, 1'b1, 1'b0);
        lows(N - 2);
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0, 1'b0);
        chk("R3 idle low does not count", brk_flag, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        chk("R3 run resumes after idle", brk_flag, 1'b1);

        finish_run();
    end
endmodule